// File: doc/BRIEF.md
# Scrambled 14b/16b Frame Transmitter

This block turns a stream of 14-bit converter samples into 16-bit line frames for a serializer. Every frame carries a 14-bit payload plus two overhead bits. The payload is the sample XORed with a pseudo-random sequence from a 17-bit linear feedback shift register. The overhead bits are a clock bit that flips on every frame and a disparity bit. A signed running-disparity counter decides when the whole payload goes out inverted. The disparity bit tells the receiver to undo that inversion before descrambling.

A frame is produced only on a clock edge where `sample_vld_i` is high. Nothing advances on other edges. A sync request starts a link synchronization sequence. It has 32 fixed alignment frames that bypass both scrambling and disparity handling. Then come 32 frames that carry the raw pseudo-random state, so the receiver can seed its own descrambler. After that, scrambled data resumes. The frame appears on `frame_o` one clock after the edge that accepts it, and it is held until the next accepted edge.

Top module: `ftx_frame_tx`

## Requirements
- R1: The frame layout is bits [13:0] payload, bit 14 clock bit and bit 15 disparity bit. While reset is asserted, `frame_o` reads 16'h0000.
- R2: In a data frame that is not inverted, the payload is `sample_i` XOR bits [13:0] of the LFSR state. The LFSR is seeded to all ones at reset. Each step shifts it left and inserts s[16]^s[13] at bit 0, which is the polynomial x^17+x^14+1. It advances 14 steps per data or PRBS frame.
- R3: The clock bit of the first frame after reset is 1. Outside the alignment frames, the clock bit inverts from one emitted frame to the next.
- R4: The running disparity is a signed value that resets to 0. When it is greater than +16 or less than -16, the frame's disparity bit is 1 and the 14-bit payload is bitwise inverted. Otherwise the disparity bit is 0 and the payload is sent unchanged.
- R5: After each emitted frame, the running disparity changes by (ones minus zeros) of the full 16-bit word. It saturates at +127 and -127.
- R6: When `sync_req_i` is high on an accepted edge, that frame and the next 31 are alignment frames. They alternate 16'hFF00 and 16'h00FF, starting with 16'hFF00.
- R7: The 32 frames after the alignment frames carry LFSR bits [13:0] as payload, with clock and disparity bits per R3 and R4. The LFSR is reloaded with all ones on the sync request and holds during the alignment frames.
- R8: After the 32nd PRBS frame, the block returns to scrambled data frames per R2.
- R9: A sync request during an alignment or PRBS frame restarts the sequence from the first alignment frame.
- R10: On an edge with `sample_vld_i` low, no state advances, `frame_o` holds its value, and `sync_req_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 14 | Converter sample for the current frame |
| sample_vld_i | input | 1 | Accept a frame on this edge |
| sync_req_i | input | 1 | Start or restart the sync sequence |
| frame_o | output | 16 | Registered 16-bit line frame |

## Verification
The hardest state to reach from the ports is a running disparity pinned at its saturation limit. Scrambled random data only drifts slowly, and inversion usually pulls the counter back. To get there, the bench reads its own model of the LFSR and of the disparity counter, then picks each sample so that the transmitted payload, after any inversion, is all zeros. This drives the counter down to -127 and holds it there. The bench then switches to all-ones payloads. The frame in which the disparity bit finally drops shows whether the counter saturated or wrapped.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  typedef enum logic [1:0] {
    SEQ_DATA  = 2'd0,
    SEQ_ALIGN = 2'd1,
    SEQ_PRBS  = 2'd2
  } seq_mode_e;
endpackage

// File: rtl/ftx_lfsr.sv
module ftx_lfsr #(
  parameter int W    = 17,
  parameter int TAP  = 14,
  parameter int STEP = 14,
  parameter logic [W-1:0] SEED = {W{1'b1}}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            reload_i,
  input  logic            hold_i,
  output logic [STEP-1:0] prbs_o
);
  logic [W-1:0] st_q, st_d, adv;

  always_comb begin
    adv = st_q;
    for (int i = 0; i < STEP; i++) adv = {adv[W-2:0], adv[W-1] ^ adv[TAP-1]};
  end

  always_comb begin
    st_d = st_q;
    if (en_i) begin
      if (reload_i)     st_d = SEED;
      else if (!hold_i) st_d = adv;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= SEED;
    else        st_q <= st_d;

  assign prbs_o = st_q[STEP-1:0];

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) st_q != '0);
endmodule

// File: rtl/ftx_seq.sv
module ftx_seq
  import ftx_pkg::*;
#(
  parameter int LEN = 32
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_i,
  input  logic      sync_req_i,
  output seq_mode_e mode_o,
  output logic      odd_o
);
  localparam int CW = $clog2(LEN);
  seq_mode_e mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_eff;
  logic last;

  assign mode_o  = sync_req_i ? SEQ_ALIGN : mode_q;
  assign cnt_eff = sync_req_i ? '0 : cnt_q;
  assign odd_o   = cnt_eff[0];
  assign last    = (cnt_eff == CW'(LEN - 1));

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    if (en_i) begin
      case (mode_o)
        SEQ_ALIGN: begin
          mode_d = last ? SEQ_PRBS : SEQ_ALIGN;
          cnt_d  = last ? '0 : cnt_eff + 1'b1;
        end
        SEQ_PRBS: begin
          mode_d = last ? SEQ_DATA : SEQ_PRBS;
          cnt_d  = last ? '0 : cnt_eff + 1'b1;
        end
        default: begin
          mode_d = SEQ_DATA;
          cnt_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= SEQ_DATA;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && sync_req_i) |=> (mode_q == SEQ_ALIGN && cnt_q == CW'(1)));
  // R8
  prbs_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !sync_req_i && mode_q == SEQ_PRBS && cnt_q == CW'(LEN - 1)) |=> mode_q == SEQ_DATA);
endmodule

// File: rtl/ftx_disp.sv
module ftx_disp #(
  parameter int FW   = 16,
  parameter int RD_W = 8,
  parameter int LIM  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [FW-1:0] word_i,
  output logic          inv_o
);
  localparam int RD_MAX = 2 ** (RD_W - 1) - 1;
  logic signed [RD_W-1:0] rd_q, rd_d;
  int ones, sum;

  always_comb begin
    ones = 0;
    for (int i = 0; i < FW; i++) ones += int'(word_i[i]);
    sum = int'(rd_q) + 2 * ones - FW;
    if (sum > RD_MAX)       sum = RD_MAX;
    else if (sum < -RD_MAX) sum = -RD_MAX;
    rd_d = en_i ? RD_W'(sum) : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;

  assign inv_o = (int'(rd_q) > LIM) || (int'(rd_q) < -LIM);

  // R5
  rd_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_q) >= -RD_MAX);
  // R5
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(rd_q));
endmodule

// File: rtl/ftx_frame_tx.sv
module ftx_frame_tx
  import ftx_pkg::*;
#(
  parameter int PAY_W    = 14,
  parameter int LFSR_W   = 17,
  parameter int LFSR_TAP = 14,
  parameter int SEQ_LEN  = 32,
  parameter int RD_W     = 8,
  parameter int RD_LIM   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PAY_W-1:0]   sample_i,
  input  logic               sample_vld_i,
  input  logic               sync_req_i,
  output logic [PAY_W+1:0]   frame_o
);
  localparam int FW = PAY_W + 2;
  localparam logic [FW-1:0] ALIGN_A = {{(FW/2){1'b1}}, {(FW/2){1'b0}}};
  localparam logic [FW-1:0] ALIGN_B = ~ALIGN_A;

  seq_mode_e        eff_mode;
  logic             eff_odd, inv, tbit_q, tbit_d, prev_align_q, prev_align_d;
  logic [PAY_W-1:0] prbs, pay;
  logic [FW-1:0]    word, frame_q, frame_d;

  ftx_seq #(.LEN(SEQ_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .en_i(sample_vld_i), .sync_req_i(sync_req_i),
    .mode_o(eff_mode), .odd_o(eff_odd));

  ftx_lfsr #(.W(LFSR_W), .TAP(LFSR_TAP), .STEP(PAY_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .en_i(sample_vld_i), .reload_i(sync_req_i),
    .hold_i(eff_mode == SEQ_ALIGN), .prbs_o(prbs));

  ftx_disp #(.FW(FW), .RD_W(RD_W), .LIM(RD_LIM)) u_disp (
    .clk(clk), .rst_n(rst_n), .en_i(sample_vld_i), .word_i(word), .inv_o(inv));

  always_comb begin
    word = '0;
    case (eff_mode)
      SEQ_ALIGN: pay = '0;
      SEQ_PRBS:  pay = prbs;
      default:   pay = sample_i ^ prbs;
    endcase
    if (eff_mode == SEQ_ALIGN) word = eff_odd ? ALIGN_B : ALIGN_A;
    else begin
      if (inv) pay = ~pay;
      word = {inv, tbit_q, pay};
    end
  end

  always_comb begin
    frame_d      = sample_vld_i ? word : frame_q;
    tbit_d       = sample_vld_i ? ~tbit_q : tbit_q;
    prev_align_d = sample_vld_i ? (eff_mode == SEQ_ALIGN) : prev_align_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      frame_q      <= '0;
      tbit_q       <= 1'b1;
      prev_align_q <= 1'b0;
    end else begin
      frame_q      <= frame_d;
      tbit_q       <= tbit_d;
      prev_align_q <= prev_align_d;
    end

  assign frame_o = frame_q;

  // R3
  clk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld_i && eff_mode != SEQ_ALIGN && !prev_align_q) |=> frame_o[PAY_W] != $past(frame_o[PAY_W]));
  // R6
  align_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld_i && sync_req_i) |=> frame_o == ALIGN_A);
  // R6
  align_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld_i && eff_mode == SEQ_ALIGN) |=> (frame_o == ALIGN_A || frame_o == ALIGN_B));
  // R4
  disp_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld_i && eff_mode != SEQ_ALIGN) |=> frame_o[FW-1] == $past(inv));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld_i |=> $stable(frame_o));
endmodule

// File: tb/ftx_frame_tx_bench.sv
`timescale 1ns/1ps
module ftx_frame_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] sample;
  logic        vld, sync;
  logic [15:0] frame_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ftx_frame_tx u_ftx_frame_tx (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .sample_vld_i(vld),
    .sync_req_i(sync), .frame_o(frame_o));

  // bench model state
  int          m_mode, m_cnt, m_rd;
  logic [16:0] m_lfsr;
  logic        m_tbit;
  logic [15:0] m_frame;

  function automatic int pop16(input logic [15:0] w);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(w[i]);
    return n;
  endfunction

  function automatic bit m_inv();
    return (m_rd > 16) || (m_rd < -16);
  endfunction

  task automatic model_reset();
    m_mode = 0; m_cnt = 0; m_rd = 0; m_lfsr = 17'h1FFFF; m_tbit = 1'b1; m_frame = 16'h0;
  endtask

  task automatic model_step(input logic [13:0] s, input logic v, input logic sy);
    int eff, ec;
    logic [13:0] p;
    logic iv;
    logic [15:0] w;
    if (!v) return;
    eff = sy ? 1 : m_mode;
    ec  = sy ? 0 : m_cnt;
    if (eff == 1) w = (ec % 2 == 0) ? 16'hFF00 : 16'h00FF;
    else begin
      p  = (eff == 2) ? m_lfsr[13:0] : (s ^ m_lfsr[13:0]);
      iv = m_inv();
      if (iv) p = ~p;
      w = {iv, m_tbit, p};
    end
    m_frame = w;
    m_rd = m_rd + 2 * pop16(w) - 16;
    if (m_rd > 127) m_rd = 127;
    if (m_rd < -127) m_rd = -127;
    m_tbit = ~m_tbit;
    if (sy) m_lfsr = 17'h1FFFF;
    else if (eff != 1)
      for (int k = 0; k < 14; k++) m_lfsr = {m_lfsr[15:0], m_lfsr[16] ^ m_lfsr[13]};
    if (eff == 1) begin
      if (ec == 31) begin m_mode = 2; m_cnt = 0; end
      else begin m_mode = 1; m_cnt = ec + 1; end
    end else if (eff == 2) begin
      if (ec == 31) begin m_mode = 0; m_cnt = 0; end
      else m_cnt = ec + 1;
    end
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [13:0] s, input logic v, input logic sy, input string req);
    @(negedge clk);
    sample = s; vld = v; sync = sy;
    model_step(s, v, sy);
    @(posedge clk);
    #1;
    chk(req, frame_o, m_frame);
  endtask

  // sample that makes the transmitted payload equal t in a data frame
  function automatic logic [13:0] pick(input logic [13:0] t);
    logic [13:0] pre = m_inv() ? ~t : t;
    return pre ^ m_lfsr[13:0];
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] prev;
    void'($urandom(32'd1357));
    model_reset();
    rst_n = 1'b0; sample = '0; vld = 1'b0; sync = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", frame_o, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    // R2, R3: random data frames, clock bit toggle
    drive(14'($urandom), 1'b1, 1'b0, "R2");
    chk("R3 first clock bit", {15'h0, frame_o[14]}, 16'h1);
    prev = frame_o;
    for (int i = 0; i < 300; i++) begin
      drive(14'($urandom), 1'b1, 1'b0, "R2");
      chk("R3", {15'h0, frame_o[14]}, {15'h0, ~prev[14]});
      prev = frame_o;
    end

    // R6, R7, R8: full sync sequence
    drive(14'($urandom), 1'b1, 1'b1, "R6");
    for (int i = 1; i < 84; i++)
      drive(14'($urandom), 1'b1, 1'b0, (i < 32) ? "R6" : (i < 64) ? "R7" : "R8");

    // R9: restart inside alignment, then inside PRBS
    drive(14'($urandom), 1'b1, 1'b1, "R9");
    for (int i = 0; i < 10; i++) drive(14'($urandom), 1'b1, 1'b0, "R9");
    drive(14'($urandom), 1'b1, 1'b1, "R9");
    for (int i = 0; i < 40; i++) drive(14'($urandom), 1'b1, 1'b0, "R9");
    drive(14'($urandom), 1'b1, 1'b1, "R9");
    for (int i = 0; i < 70; i++) drive(14'($urandom), 1'b1, 1'b0, "R9");

    // R10: invalid edges hold output and ignore sync
    prev = frame_o;
    for (int i = 0; i < 6; i++) begin
      drive(14'($urandom), 1'b0, 1'b1, "R10");
      chk("R10 hold", frame_o, prev);
    end
    drive(14'($urandom), 1'b1, 1'b0, "R10");

    // R4: all-ones payloads push disparity past +16 and force inversion
    for (int i = 0; i < 12; i++) drive(pick(14'h3FFF), 1'b1, 1'b0, "R4");
    // R5: zero payloads pin disparity at the negative limit, then climb back
    for (int i = 0; i < 30; i++) drive(pick(14'h0000), 1'b1, 1'b0, "R5");
    for (int i = 0; i < 30; i++) drive(pick(14'h3FFF), 1'b1, 1'b0, "R5");

    // mixed random traffic
    for (int i = 0; i < 3000; i++)
      drive(14'($urandom), ($urandom % 4) != 0, ($urandom % 60) == 0, "R2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule